// File: doc/BRIEF.md
# Identifier CRC-8 Checker

This block checks a short byte message against an 8-bit cyclic redundancy code. Bytes arrive one per clock on a valid/ready stream. Each byte is folded into a running code by eight unrolled polynomial steps in combinational logic. When the byte marked last is taken, the block registers the finished code. It also registers whether the code equals the expected value and raises a one-cycle done pulse.

The expected value can come from two places, chosen by `hdr_mode`. In header mode the first byte of each message is the stored check byte: it is captured and left out of the code, so a nine-byte identifier record (check byte, then eight data bytes) can be streamed straight through. In direct mode every byte is covered and the expected value is read from `exp_crc` on the last beat. `hdr_mode` must stay steady for the whole of a message.

The stream follows the usual valid/ready rule. A beat is taken on a rising edge where both `in_valid` and `in_ready` are high. The block only holds off its source while `clr` is high. While `in_ready` is low, the source must keep its beat unchanged.

Top module: `id_crc8_checker`

## Requirements
- R1: After reset, `crc_out` is 0xFF, `match` and `done` are 0, and `in_ready` is 1.
- R2: The code starts from 0xFF for every message. Each covered byte is XORed into the whole register, followed by eight steps of shift-left-by-one with XOR 0x07 when the bit shifted out was 1. No final inversion or bit reversal is applied, and `crc_out` shows the code of the latest message.
- R3: `done` is high for exactly the one cycle after the edge that takes a beat with `in_last` high, and at no other time.
- R4: In direct mode (`hdr_mode`=0) `match` is 1 exactly when the code equals `exp_crc` as sampled with the last beat.
- R5: In header mode (`hdr_mode`=1) the first byte of a message is the expected value and is excluded from the code. A message made of that single byte yields code 0xFF.
- R6: While `clr` is high, `in_ready` is 0 and offered beats are not taken. After `clr`, a partly received message is dropped and the next message starts from 0xFF and a fresh first byte.
- R7: Messages may follow each other with no idle cycle between them, and each still starts from 0xFF.
- R8: With `clr` low, `in_ready` is 1. `crc_out` and `match` hold their values until the next last beat is taken, regardless of idle cycles or partial messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Drops the message in progress and presets the code |
| hdr_mode | input | 1 | 1: first byte is the check byte; 0: expected value from exp_crc |
| exp_crc | input | 8 | Expected code in direct mode, sampled on the last beat |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Beat is the final byte of a message |
| crc_out | output | 8 | Code of the most recent message |
| match | output | 1 | Code of the most recent message equals its expected value |
| done | output | 1 | One-cycle pulse after a message ends |

## Verification
The bench sends messages back to back with no gap, so a design that failed to re-preset after a last beat would carry one code into the next. It sends header-only messages, where a design that still folded the check byte in would report something other than 0xFF. It also issues a clear in the middle of a message while offering a beat; a design that took that beat or kept the partial code would produce a wrong final code. Random idle gaps test that done does not pulse and results do not drift outside last beats, and random wrong check bytes make sure match can also go low.

// File: rtl/id_crc8_pkg.sv
package id_crc8_pkg;
  localparam int unsigned CRC_W    = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
  localparam logic [CRC_W-1:0] CRC_INIT = 8'hFF;
  typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/id_crc8_byte_step.sv
module id_crc8_byte_step #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] POLY = 8'h07
) (
  input  logic [W-1:0] crc_in,
  input  logic [W-1:0] din,
  output logic [W-1:0] crc_nxt
);
  logic [W-1:0] stage [0:W];

  assign stage[0] = crc_in ^ din;

  for (genvar s = 0; s < W; s++) begin : g_step
    assign stage[s+1] = {stage[s][W-2:0], 1'b0} ^ (stage[s][W-1] ? POLY : '0);
  end

  assign crc_nxt = stage[W];
endmodule

// File: rtl/id_crc8_frame_ctrl.sv
module id_crc8_frame_ctrl #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         beat,
  input  logic         last,
  input  logic         hdr_mode,
  input  logic [W-1:0] din,
  output logic         first,
  output logic [W-1:0] hdr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first <= 1'b1;
      hdr_q <= '0;
    end else if (clr) begin
      first <= 1'b1;
    end else if (beat) begin
      first <= last;
      if (first && hdr_mode) hdr_q <= din;
    end
  end
endmodule

// File: rtl/id_crc8_result.sv
module id_crc8_result #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] INIT = 8'hFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         end_beat,
  input  logic [W-1:0] final_crc,
  input  logic [W-1:0] expected,
  output logic [W-1:0] res_q,
  output logic         match_q,
  output logic         done_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= INIT;
      match_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= end_beat;
      if (end_beat) begin
        res_q   <= final_crc;
        match_q <= (final_crc == expected);
      end
    end
  end
endmodule

// File: rtl/id_crc8_checker.sv
module id_crc8_checker
  import id_crc8_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W-1:0] POLY = CRC_POLY,
  parameter logic [W-1:0] INIT = CRC_INIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         hdr_mode,
  input  logic [W-1:0] exp_crc,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic [W-1:0] crc_out,
  output logic         match,
  output logic         done
);
  logic         beat, first, skip, end_beat;
  logic [W-1:0] crc_q, step_out, final_crc, expected, hdr_q;

  assign in_ready = !clr;
  assign beat     = in_valid && in_ready;
  assign end_beat = beat && in_last;
  assign skip     = first && hdr_mode;

  id_crc8_byte_step #(.W(W), .POLY(POLY)) u_step (
    .crc_in (crc_q),
    .din    (in_data),
    .crc_nxt(step_out)
  );

  id_crc8_frame_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .beat    (beat),
    .last    (in_last),
    .hdr_mode(hdr_mode),
    .din     (in_data),
    .first   (first),
    .hdr_q   (hdr_q)
  );

  assign final_crc = skip ? crc_q : step_out;
  assign expected  = skip ? in_data : (hdr_mode ? hdr_q : exp_crc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             crc_q <= INIT;
    else if (clr)           crc_q <= INIT;
    else if (beat) begin
      if (in_last)          crc_q <= INIT;
      else if (!skip)       crc_q <= step_out;
    end
  end

  id_crc8_result #(.W(W), .INIT(INIT)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .end_beat (end_beat),
    .final_crc(final_crc),
    .expected (expected),
    .res_q    (crc_out),
    .match_q  (match),
    .done_q   (done)
  );
endmodule

// File: rtl/id_crc8_checker_sva.sv
module id_crc8_checker_sva #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_last,
  input logic [W-1:0] crc_out,
  input logic         match,
  input logic         done
);
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> done); // R3
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && in_last) |=> !done); // R3
  AST_CLR_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !in_ready); // R6
  AST_READY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> in_ready); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && in_last) |=> ($stable(crc_out) && $stable(match))); // R8
endmodule

bind id_crc8_checker id_crc8_checker_sva #(.W(W)) u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr     (clr),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .in_last (in_last),
  .crc_out (crc_out),
  .match   (match),
  .done    (done)
);

// File: tb/id_crc8_checker_tb_top.sv
`timescale 1ns/1ps
module id_crc8_checker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       hdr_mode = 1'b0;
  logic [7:0] exp_crc = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic [7:0] crc_out;
  logic       match;
  logic       done;

  int checks = 0;
  int errors = 0;
  logic [7:0] mbuf [0:15];

  always #2 clk = ~clk;

  id_crc8_checker dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hdr_mode(hdr_mode), .exp_crc(exp_crc),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .crc_out(crc_out), .match(match), .done(done)
  );

  function automatic logic [7:0] ref_crc(int start, int n);
    logic [7:0] v = 8'hFF;
    for (int i = start; i < start + n; i++) begin
      v ^= mbuf[i];
      for (int j = 0; j < 8; j++) v = v[7] ? ((v << 1) ^ 8'h07) : (v << 1);
    end
    return v;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; ends at the negedge after the last beat is taken.
  task automatic send_msg(input logic mode, input int n, input logic [7:0] xcrc,
                          input logic gaps);
    logic [7:0] want;
    logic       want_m;
    hdr_mode = mode;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = mbuf[i];
      in_last  = (i == n - 1);
      exp_crc  = (i == n - 1) ? xcrc : ~xcrc;
      @(negedge clk);
      in_valid = 1'b0;
      if (i != n - 1) begin
        chk(done == 1'b0, "R3 done early", done, 0);
        if (gaps) begin
          for (int g = 0; g < int'($urandom_range(0, 2)); g++) begin
            @(negedge clk);
            chk(done == 1'b0, "R3 done in gap", done, 0);
          end
        end
      end
    end
    in_last = 1'b0;
    want   = mode ? ref_crc(1, n - 1) : ref_crc(0, n);
    want_m = mode ? (want == mbuf[0]) : (want == xcrc);
    chk(done == 1'b1, "R3 done pulse", done, 1);
    chk(crc_out == want, mode ? "R5 header code" : "R2 code", crc_out, want);
    chk(match == want_m, mode ? "R5 header match" : "R4 match", match, want_m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(crc_out == 8'hFF, "R1 crc reset", crc_out, 8'hFF);
    chk(match == 1'b0, "R1 match reset", match, 0);
    chk(done == 1'b0, "R1 done reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);

    // R5 header-only message: code 0xFF
    mbuf[0] = 8'hFF;
    send_msg(1'b1, 1, 8'h00, 1'b0);
    chk(crc_out == 8'hFF, "R5 empty code", crc_out, 8'hFF);
    // R7 back to back: identifier record, zero gap
    for (int i = 1; i <= 8; i++) mbuf[i] = 8'(i * 17);
    mbuf[0] = ref_crc(1, 8);
    send_msg(1'b1, 9, 8'h00, 1'b0);
    // R7 direct mode right after, still preset
    for (int i = 0; i < 4; i++) mbuf[i] = 8'h00;
    send_msg(1'b0, 4, ref_crc(0, 4), 1'b0);
    chk(match == 1'b1, "R7 back-to-back match", match, 1);

    // R8 hold through idle cycles
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R3 done one cycle", done, 0);
    chk(crc_out == ref_crc(0, 4), "R8 hold code", crc_out, ref_crc(0, 4));
    chk(match == 1'b1, "R8 hold match", match, 1);

    // R6 clear mid-message with a beat offered
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_data = 8'hA0 + 8'(i); hdr_mode = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(crc_out == ref_crc(0, 4), "R8 partial no effect", crc_out, ref_crc(0, 4));
    clr = 1'b1; in_valid = 1'b1; in_data = 8'h5A; in_last = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R6 ready low", in_ready, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 beat ignored", done, 0);
    clr = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R8 ready back", in_ready, 1);
    for (int i = 0; i < 5; i++) mbuf[i] = 8'h3C ^ 8'(i);
    send_msg(1'b1, 5, 8'h00, 1'b0);

    // random messages, R2 R4 R5
    for (int k = 0; k < 60; k++) begin
      automatic logic m = 1'($urandom);
      automatic int n = int'($urandom_range(1, 12));
      automatic logic [7:0] x;
      for (int i = 0; i < n; i++) mbuf[i] = 8'($urandom);
      x = ref_crc(0, n);
      if ($urandom_range(0, 1) == 1) x = 8'($urandom);
      if (m && ($urandom_range(0, 1) == 1)) mbuf[0] = ref_crc(1, n - 1);
      send_msg(m, n, x, 1'($urandom));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule